// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache Controller

This block is the private cache of one processor on a shared single bus. It is direct-mapped and holds one data word per line. Every processor store goes to memory in a bus write cycle, so memory always holds current data. Other caches watch those write cycles and drop their copies.

On a read hit the word comes straight from the local line and the bus stays idle. A read miss asks for the bus, reads the word from memory and puts it into the indexed line. The old occupant is thrown away with no write-back. A write hit updates the line and writes the word through to memory. A write miss first fetches the line and then writes it through in the same bus tenure.

A snoop port carries the address and master identifier of every bus write. A write by another master that matches a valid local line clears that line. Writes tagged with this controller's own identifier are ignored.

Top module: `wt_snoop_cache`

## Requirements
- R1: After synchronous reset, cpu_ready, bus_req and bus_valid are low and every line is invalid, so the first read of any address takes a bus read.
- R2: A read whose index holds a valid line with an equal tag returns the cached word with no bus cycle, and cpu_ready is high in the cycle after the request is accepted.
- R3: A read miss makes exactly one bus read (bus_we low) at the requested address, returns the word on cpu_rdata, and installs it so that a repeated read hits.
- R4: A write hit makes exactly one bus write carrying the request address and data, with no bus read, and the line then holds the new word.
- R5: A write miss makes one bus read followed by one bus write in a single bus tenure, and the line then holds the written word.
- R6: A miss to an occupied index replaces the line with no write cycle for the old content, and the old address then misses.
- R7: A snoop from a master whose identifier differs from OWN_ID, whose address matches a valid line, invalidates it, so the next read of that address makes a bus read and returns the new memory word.
- R8: A snoop from another master to the same index but a different tag leaves the line valid, so the next read of the cached address still hits.
- R9: A snoop invalidation that lands in the same cycle as the acceptance of a read hit to the same address wins, and the read is handled as a miss.
- R10: A snoop carrying OWN_ID has no effect on the cache contents.
- R11: bus_valid is only high while bus_req and bus_gnt are high. A command holds its address until it is acknowledged. bus_req falls in the cycle after the last acknowledge. cpu_ready is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word address; low INDEX_W bits index, rest is tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held while bus_req stays high |
| bus_valid | output | 1 | Bus command active |
| bus_we | output | 1 | 1 for a bus write, 0 for a bus read |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Memory read data, valid with bus_ack |
| bus_ack | input | 1 | Memory completes the current command |
| snoop_valid | input | 1 | A bus write was seen |
| snoop_id | input | ID_W | Identifier of the writing master |
| snoop_addr | input | ADDR_W | Address of the snooped write |

## Verification
A stale valid bit or tag in this controller shows up at the ports on the next request to that index. If a line wrongly stays valid, a read returns the old word with no bus read. If a line is wrongly dropped, an extra bus read appears before cpu_ready. Counting bus reads and writes per request, and comparing read data against a reference memory, exposes the fault within one request. A broken FSM shows up as a wrong read/write order on the bus, or as cpu_ready arriving in the wrong cycle.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } wtc_state_e;
endpackage

// File: rtl/wtc_store.sv
module wtc_store #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4,
  parameter int ID_W    = 2,
  parameter int OWN_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snoop_valid,
  input  logic [ID_W-1:0]   snoop_id,
  input  logic [ADDR_W-1:0] snoop_addr
);
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [LINES-1:0] line_ok;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  logic [INDEX_W-1:0] lk_idx, fl_idx, sn_idx;
  logic [TAG_W-1:0]   lk_tag, sn_tag;
  logic               sn_kill;

  assign lk_idx = lk_addr[INDEX_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:INDEX_W];
  assign fl_idx = fill_addr[INDEX_W-1:0];
  assign sn_idx = snoop_addr[INDEX_W-1:0];
  assign sn_tag = snoop_addr[ADDR_W-1:INDEX_W];

  // another master's write that matches a valid line
  assign sn_kill = snoop_valid && (snoop_id != ID_W'(OWN_ID)) &&
                   line_ok[sn_idx] && (tag_mem[sn_idx] == sn_tag);

  // a same-cycle invalidation of the looked-up line beats the hit
  assign lk_hit  = line_ok[lk_idx] && (tag_mem[lk_idx] == lk_tag) &&
                   !(sn_kill && (sn_idx == lk_idx));
  assign lk_data = data_mem[lk_idx];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[fl_idx]  <= fill_addr[ADDR_W-1:INDEX_W];
      data_mem[fl_idx] <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_ok <= '0;
    end else begin
      if (fill_en) line_ok[fl_idx] <= 1'b1;
      if (sn_kill) line_ok[sn_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  wtc_state_e        st;
  logic              lat_we;
  logic              need_fetch;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  assign fill_en   = bus_ack && ((st == ST_READ) || (st == ST_WRITE));
  assign fill_addr = lat_addr;
  assign fill_data = (st == ST_READ) ? bus_rdata : lat_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      lat_we     <= 1'b0;
      need_fetch <= 1'b0;
      lat_addr   <= '0;
      lat_wdata  <= '0;
      cpu_ready  <= 1'b0;
      cpu_rdata  <= '0;
      bus_req    <= 1'b0;
      bus_valid  <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cpu_req) begin
            lat_we    <= cpu_we;
            lat_addr  <= cpu_addr;
            lat_wdata <= cpu_wdata;
            if (!cpu_we && lk_hit) begin
              cpu_rdata <= lk_data;
              cpu_ready <= 1'b1;
              st        <= ST_RESP;
            end else begin
              need_fetch <= !lk_hit;
              bus_req    <= 1'b1;
              st         <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (bus_gnt) begin
            bus_valid <= 1'b1;
            bus_addr  <= lat_addr;
            if (need_fetch) begin
              bus_we <= 1'b0;
              st     <= ST_READ;
            end else begin
              bus_we    <= 1'b1;
              bus_wdata <= lat_wdata;
              st        <= ST_WRITE;
            end
          end
        end
        ST_READ: begin
          if (bus_ack) begin
            if (lat_we) begin
              bus_we    <= 1'b1;
              bus_wdata <= lat_wdata;
              st        <= ST_WRITE;
            end else begin
              cpu_rdata <= bus_rdata;
              cpu_ready <= 1'b1;
              bus_valid <= 1'b0;
              bus_req   <= 1'b0;
              st        <= ST_RESP;
            end
          end
        end
        ST_WRITE: begin
          if (bus_ack) begin
            bus_valid <= 1'b0;
            bus_we    <= 1'b0;
            bus_req   <= 1'b0;
            cpu_ready <= 1'b1;
            st        <= ST_RESP;
          end
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4,
  parameter int ID_W    = 2,
  parameter int OWN_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              snoop_valid,
  input  logic [ID_W-1:0]   snoop_id,
  input  logic [ADDR_W-1:0] snoop_addr
);
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              fill_en;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] fill_data;

  wtc_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W),
    .ID_W(ID_W), .OWN_ID(OWN_ID)
  ) u_store (
    .clk(clk), .rst(rst),
    .lk_addr(cpu_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .snoop_valid(snoop_valid), .snoop_id(snoop_id), .snoop_addr(snoop_addr)
  );

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_valid,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr
);
  p_valid_owns_bus_r11: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_req && bus_gnt));

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  p_cmd_held_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));

  p_write_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ack && bus_we) |=> (cpu_ready && !bus_valid && !bus_req));

  p_read_then_write_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ack && !bus_we) |=>
      ((cpu_ready && !bus_valid) || (bus_valid && bus_we && $stable(bus_addr))));
endmodule

bind wt_snoop_cache wtc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_ack(bus_ack), .bus_addr(bus_addr)
);

// File: tb/wt_snoop_cache_tb.sv
module wt_snoop_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int INDEX_W = 4;
  localparam int ID_W    = 2;
  localparam int OWN_ID  = 0;
  localparam int LINES   = 1 << INDEX_W;
  localparam int TAG_W   = ADDR_W - INDEX_W;
  localparam int MEMSZ   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req, bus_valid, bus_we;
  logic bus_gnt = 1'b0, bus_ack = 1'b0;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic snoop_valid = 1'b0;
  logic [ID_W-1:0] snoop_id = '0;
  logic [ADDR_W-1:0] snoop_addr = '0;

  int errors = 0, checks = 0;
  int n_rd = 0, n_wr = 0, dly = 0;
  logic [DATA_W-1:0] mem [MEMSZ];
  logic              rv [LINES];
  logic [TAG_W-1:0]  rt [LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_snoop_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W),
                   .ID_W(ID_W), .OWN_ID(OWN_ID)) u_dut (.*);

  // arbiter and memory model
  always @(negedge clk) begin
    if (!bus_req) bus_gnt = 1'b0;
    else if (!bus_gnt) bus_gnt = ($urandom % 2) == 0;
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_valid) begin
      if (dly == 0) begin
        if (bus_we) begin mem[bus_addr] = bus_wdata; n_wr++; end
        else begin bus_rdata = mem[bus_addr]; n_rd++; end
        bus_ack = 1'b1;
        dly = $urandom % 3;
      end else dly--;
    end
  end

  function automatic logic ref_hit(input logic [ADDR_W-1:0] a);
    return rv[a[INDEX_W-1:0]] && (rt[a[INDEX_W-1:0]] == a[ADDR_W-1:INDEX_W]);
  endfunction

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one processor access; with_snoop drives another master's write to the same address in the accept cycle
  task automatic do_op(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                       input bit with_snoop, input logic [DATA_W-1:0] snd, input string tag);
    int rd0, wr0, cyc;
    logic hit, exp_hit;
    logic [DATA_W-1:0] got;
    hit = ref_hit(a);
    exp_hit = hit && !with_snoop;
    rd0 = n_rd; wr0 = n_wr; cyc = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (with_snoop) begin
      snoop_valid = 1'b1; snoop_id = ID_W'(OWN_ID + 1); snoop_addr = a; mem[a] = snd;
    end
    do begin
      @(negedge clk);
      snoop_valid = 1'b0;
      cyc++;
    end while (!cpu_ready && cyc < 300);
    got = cpu_rdata;
    cpu_req = 1'b0;
    if (cyc >= 300) begin
      checks++; errors++;
      $display("FAIL %s actual=timeout expected=ready", tag);
      return;
    end
    chk({tag, " bus reads"}, DATA_W'(n_rd - rd0), exp_hit ? 0 : 1);
    chk({tag, " bus writes"}, DATA_W'(n_wr - wr0), we ? 1 : 0);
    if (!we) chk({tag, " rdata"}, got, mem[a]);
    else     chk({tag, " memory updated"}, mem[a], wd);
    if (!we && exp_hit) chk({tag, " hit latency"}, DATA_W'(cyc), 1);
    rv[a[INDEX_W-1:0]] = 1'b1;
    rt[a[INDEX_W-1:0]] = a[ADDR_W-1:INDEX_W];
  endtask

  task automatic snoop(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_id = id; snoop_addr = a;
    if (id != ID_W'(OWN_ID)) begin
      mem[a] = d;
      if (ref_hit(a)) rv[a[INDEX_W-1:0]] = 1'b0;
    end
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int t, input int i);
    return ADDR_W'((t << INDEX_W) | i);
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < MEMSZ; i++) mem[i] = DATA_W'(32'hA000_0000 + i * 7);
    for (int i = 0; i < LINES; i++) begin rv[i] = 1'b0; rt[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready low", DATA_W'(cpu_ready), 0);
    chk("R1 bus_req low", DATA_W'(bus_req), 0);
    chk("R1 bus_valid low", DATA_W'(bus_valid), 0);

    do_op(0, mk(1, 3), 0, 0, 0, "R1 R3 first read miss");
    do_op(0, mk(1, 3), 0, 0, 0, "R2 R3 repeat read hit");
    do_op(1, mk(1, 3), 32'h1111_2222, 0, 0, "R4 write hit");
    do_op(0, mk(1, 3), 0, 0, 0, "R4 read after write hit");
    do_op(1, mk(2, 5), 32'h3333_4444, 0, 0, "R5 write miss");
    do_op(0, mk(2, 5), 0, 0, 0, "R5 read after write miss");
    do_op(0, mk(3, 5), 0, 0, 0, "R6 replacing read");
    do_op(0, mk(2, 5), 0, 0, 0, "R6 old address misses");
    snoop(ID_W'(OWN_ID + 2), mk(2, 5), 32'h5555_6666);
    do_op(0, mk(2, 5), 0, 0, 0, "R7 read after foreign snoop");
    snoop(ID_W'(OWN_ID + 1), mk(7, 5), 32'h7777_8888);
    do_op(0, mk(2, 5), 0, 0, 0, "R8 other tag snoop keeps line");
    do_op(0, mk(1, 9), 0, 0, 0, "R9 prime line");
    do_op(0, mk(1, 9), 0, 1, 32'h9999_aaaa, "R9 same-cycle snoop wins");
    do_op(1, mk(1, 9), 32'hbbbb_cccc, 0, 0, "R10 write before own snoop");
    snoop(ID_W'(OWN_ID), mk(1, 9), 0);
    do_op(0, mk(1, 9), 0, 0, 0, "R10 own snoop ignored");

    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a;
      a = mk($urandom % 4, $urandom % LINES);
      if ($urandom % 6 == 0)
        snoop(ID_W'($urandom % (1 << ID_W)), a, $urandom);
      else if ($urandom % 3 == 0)
        do_op(1, a, $urandom, 0, 0, "R4 R5 random write");
      else
        do_op(0, a, 0, 0, 0, "R2 R3 R11 random read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule